// File: doc/BRIEF.md
# Micro-TLB with Deferred Invalidation

This block is a small translation cache built from flip-flops. It sits between a load/store or fetch pipeline and a larger, less associative joint TLB. Every entry is compared against the incoming virtual page and address-space identifier in the same cycle. A match returns the physical frame and the six access-permission bits at once. On a miss the block raises a refill request toward the joint TLB and holds it until that side answers with the descriptor. The returned descriptor is then written into the slot that a round-robin pointer selects.

Entries are never dropped because the joint TLB replaced its own copy of them. A victim overwritten during a joint-TLB refill stays valid here, so the higher associativity of this cache covers for the joint TLB's limited number of ways. Entries are cleared only by an explicit flush. A flush is either an ordinary joint-TLB write or a stand-alone invalidate command. A joint-TLB write flagged as "keep" leaves the cache alone. The same module serves both sides of the core: it is instantiated with eight entries for data and four entries for instructions.

Top module: `utlb_cache`

## Requirements
- R1: After reset no lookup hits, `fill_req` is low and the replacement pointer selects slot 0.
- R2: A lookup with `lk_valid` high hits when an entry is valid, its virtual page equals `lk_vpn`, and its ASID equals `lk_asid`. In that same cycle, `lk_pfn` and `lk_perm` carry that entry's frame and permission bits. A stored entry never matches a lookup with a different ASID unless it is global.
- R3: A lookup that misses while no request is pending raises `fill_req` from the next cycle. `fill_vpn` and `fill_asid` then carry the missed page and ASID. Request, page and ASID stay unchanged, whatever the later lookups are, until `fill_ack` is sampled.
- R4: A `fill_ack` sampled while a request is pending ends the request in the next cycle. Unless a flush is sampled at the same edge, it also installs the requested page and ASID with `fill_pfn`, `fill_perm` and `fill_global`. From the next cycle on, a lookup of that page and ASID hits.
- R5: Installs go to slots 0, 1, … ENTRIES-1 in turn and then wrap. The (ENTRIES+1)-th install after reset therefore replaces the first one, and the other ENTRIES-1 stay resident.
- R6: A joint-TLB write with `jt_wr_keep` high has no effect on any resident entry.
- R7: A joint-TLB write with `jt_wr_keep` low invalidates every entry, so no lookup hits in the following cycle.
- R8: `inv_cmd` invalidates every entry, so no lookup hits in the following cycle.
- R9: When a flush and `fill_ack` are sampled at the same edge, the flush wins. The filled page is not left valid, and the pending request still ends.
- R10: A `fill_ack` sampled while no request is pending installs nothing and leaves `fill_req` low.
- R11: With `lk_valid` low, `lk_hit` stays low whatever the lookup page and ASID are.
- R12: An entry installed with `fill_global` high hits for its page under any lookup ASID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_asid | input | ASID_W | Address-space identifier of the lookup |
| lk_hit | output | 1 | Lookup matched a resident entry (combinational) |
| lk_pfn | output | PFN_W | Physical frame of the matching entry |
| lk_perm | output | 6 | Permission bits of the matching entry, as stored |
| fill_req | output | 1 | Refill request to the joint TLB |
| fill_vpn | output | VPN_W | Page being requested |
| fill_asid | output | ASID_W | ASID being requested |
| fill_ack | input | 1 | Joint TLB returns the descriptor this cycle |
| fill_pfn | input | PFN_W | Returned physical frame |
| fill_perm | input | 6 | Returned permission bits |
| fill_global | input | 1 | Returned entry ignores ASID |
| jt_wr | input | 1 | Joint-TLB write command issued |
| jt_wr_keep | input | 1 | The joint-TLB write leaves this cache untouched |
| inv_cmd | input | 1 | Stand-alone invalidate command |

## Verification
A lookup result is combinational: the bench drives the page at the falling edge and reads `lk_hit`, `lk_pfn` and `lk_perm` one nanosecond later, before any rising edge. The request, the installs and the flushes each pass through one register. The bench therefore reads `fill_req`, `fill_vpn` and `fill_asid` at the falling edge after the edge that sampled the miss or the acknowledgement. It probes an entry's presence in the cycle after the install or flush edge. Each probe lowers `lk_valid` before the next rising edge, so a probe that misses never starts a request the scenario did not ask for.

// File: rtl/utlb_cache.sv
module utlb_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [5:0]        lk_perm,
  output logic              fill_req,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [ASID_W-1:0] fill_asid,
  input  logic              fill_ack,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [5:0]        fill_perm,
  input  logic              fill_global,
  input  logic              jt_wr,
  input  logic              jt_wr_keep,
  input  logic              inv_cmd
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, glb_q, match;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [5:0]         perm_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;
  logic               req_q;
  logic [VPN_W-1:0]   req_vpn_q;
  logic [ASID_W-1:0]  req_asid_q;

  wire flush   = (jt_wr & ~jt_wr_keep) | inv_cmd;
  wire take    = req_q & fill_ack;
  wire install = take & ~flush;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
      wire sel = install && (rr_q == PTR_W'(gi));

      assign match[gi] = lk_valid & vld_q[gi] & (vpn_q[gi] == lk_vpn) &
                         (glb_q[gi] | (asid_q[gi] == lk_asid));

      always_ff @(posedge clk) begin
        if (!rst_n)     vld_q[gi] <= 1'b0;
        else if (flush) vld_q[gi] <= 1'b0;
        else if (sel)   vld_q[gi] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (sel) begin
          vpn_q[gi]  <= req_vpn_q;
          asid_q[gi] <= req_asid_q;
          pfn_q[gi]  <= fill_pfn;
          perm_q[gi] <= fill_perm;
          glb_q[gi]  <= fill_global;
        end
      end
    end
  endgenerate

  assign lk_hit = |match;

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_pfn  = pfn_q[i];
        lk_perm = perm_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rr_q <= '0;
    else if (install) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      req_vpn_q  <= '0;
      req_asid_q <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else if (!req_q && lk_valid && !lk_hit) begin
      req_q      <= 1'b1;
      req_vpn_q  <= lk_vpn;
      req_asid_q <= lk_asid;
    end
  end

  assign fill_req  = req_q;
  assign fill_vpn  = req_vpn_q;
  assign fill_asid = req_asid_q;
endmodule

module utlb_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic              fill_req,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic [ASID_W-1:0] fill_asid,
  input logic              fill_ack,
  input logic              jt_wr,
  input logic              jt_wr_keep,
  input logic              inv_cmd,
  input logic [ENTRIES-1:0] match
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !fill_req);

  // R2
  unique_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));

  // R3
  miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_hit && !fill_req |=>
      fill_req && fill_vpn == $past(lk_vpn) && fill_asid == $past(lk_asid));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_ack |=> fill_req && $stable(fill_vpn) && $stable(fill_asid));

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_ack |=> !fill_req);

  // R4
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_ack && !(jt_wr && !jt_wr_keep) && !inv_cmd |=>
      ((lk_valid && lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid)) -> lk_hit));

  // R7 R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jt_wr && !jt_wr_keep) || inv_cmd |=> !lk_hit);

  // R11
  idle_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |-> !lk_hit);
endmodule

bind utlb_cache utlb_cache_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (.*);

// File: tb/utlb_cache_tb.sv
`timescale 1ns/1ps
module utlb_cache_tb;
  localparam int N = 8;
  localparam int VW = 19;
  localparam int AW = 8;
  localparam int PW = 20;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic lk_hit;
  logic [PW-1:0] lk_pfn;
  logic [5:0] lk_perm;
  logic fill_req;
  logic [VW-1:0] fill_vpn;
  logic [AW-1:0] fill_asid;
  logic fill_ack = 0;
  logic [PW-1:0] fill_pfn = '0;
  logic [5:0] fill_perm = '0;
  logic fill_global = 0;
  logic jt_wr = 0, jt_wr_keep = 0, inv_cmd = 0;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  utlb_cache #(.ENTRIES(N), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0; lk_valid = 0; fill_ack = 0; jt_wr = 0; jt_wr_keep = 0; inv_cmd = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic probe(input logic [VW-1:0] v, input logic [AW-1:0] a,
                       output logic h, output logic [PW-1:0] p, output logic [5:0] pm);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_asid = a;
    #1;
    h = lk_hit; p = lk_pfn; pm = lk_perm;
    #1 lk_valid = 0;
  endtask

  task automatic fill_one(input logic [VW-1:0] v, input logic [AW-1:0] a,
                          input logic [PW-1:0] p, input logic [5:0] pm, input logic g);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_asid = a;
    @(negedge clk);
    lk_valid = 0;
    fill_ack = 1; fill_pfn = p; fill_perm = pm; fill_global = g;
    @(negedge clk);
    fill_ack = 0; fill_global = 0;
  endtask

  task automatic t_reset();
    logic h; logic [PW-1:0] p; logic [5:0] pm;
    reset_dut();
    #1 check(fill_req == 0, "R1 fill_req after reset", fill_req, 0);
    probe(19'h0, 8'h0, h, p, pm);
    check(h == 0, "R1 no hit after reset", h, 0);
  endtask

  task automatic t_hit_rules();
    logic h; logic [PW-1:0] p; logic [5:0] pm;
    reset_dut();
    fill_one(19'h1A2B, 8'h05, 20'hABCDE, 6'b101101, 0);
    probe(19'h1A2B, 8'h05, h, p, pm);
    check(h == 1, "R2 hit same page and ASID", h, 1);
    check(p == 20'hABCDE, "R2 frame", p, 20'hABCDE);
    check(pm == 6'b101101, "R2 perm", pm, 6'b101101);
    probe(19'h1A2B, 8'h06, h, p, pm);
    check(h == 0, "R2 ASID mismatch misses", h, 0);
    probe(19'h1A2C, 8'h05, h, p, pm);
    check(h == 0, "R2 page mismatch misses", h, 0);
    fill_one(19'h0777, 8'h05, 20'h12345, 6'b111000, 1);
    probe(19'h0777, 8'hF9, h, p, pm);
    check(h == 1, "R12 global hits other ASID", h, 1);
    check(p == 20'h12345, "R12 global frame", p, 20'h12345);
    @(negedge clk);
    lk_valid = 0; lk_vpn = 19'h1A2B; lk_asid = 8'h05;
    #1 check(lk_hit == 0, "R11 no hit when lookup idle", lk_hit, 0);
  endtask

  task automatic t_miss_request();
    logic h; logic [PW-1:0] p; logic [5:0] pm;
    reset_dut();
    @(negedge clk);
    lk_valid = 1; lk_vpn = 19'h002A; lk_asid = 8'h03;
    @(negedge clk);
    check(fill_req == 1, "R3 request raised", fill_req, 1);
    check(fill_vpn == 19'h002A, "R3 request page", fill_vpn, 19'h002A);
    check(fill_asid == 8'h03, "R3 request ASID", fill_asid, 8'h03);
    lk_vpn = 19'h003B; lk_asid = 8'h04;
    repeat (3) @(negedge clk);
    check(fill_req == 1, "R3 request held", fill_req, 1);
    check(fill_vpn == 19'h002A, "R3 page stable under new misses", fill_vpn, 19'h002A);
    check(fill_asid == 8'h03, "R3 ASID stable", fill_asid, 8'h03);
    lk_valid = 0;
    fill_ack = 1; fill_pfn = 20'h0BEEF; fill_perm = 6'b000111;
    @(negedge clk);
    fill_ack = 0;
    check(fill_req == 0, "R4 request ends on ack", fill_req, 0);
    probe(19'h002A, 8'h03, h, p, pm);
    check(h == 1 && p == 20'h0BEEF, "R4 installed entry hits", p, 20'h0BEEF);
    probe(19'h003B, 8'h04, h, p, pm);
    check(h == 0, "R4 later miss was not installed", h, 0);
  endtask

  task automatic t_round_robin();
    logic h; logic [PW-1:0] p; logic [5:0] pm;
    reset_dut();
    for (int i = 0; i <= N; i++)
      fill_one(VW'(19'h100 + i), 8'h01, PW'(20'h500 + i), 6'b001001, 0);
    probe(19'h100, 8'h01, h, p, pm);
    check(h == 0, "R5 first install replaced after wrap", h, 0);
    for (int i = 1; i <= N; i++) begin
      probe(VW'(19'h100 + i), 8'h01, h, p, pm);
      check(h == 1 && p == PW'(20'h500 + i), "R5 later installs resident", p, PW'(20'h500 + i));
    end
  endtask

  task automatic t_writes();
    logic h; logic [PW-1:0] p; logic [5:0] pm;
    reset_dut();
    fill_one(19'h0010, 8'h02, 20'h00AAA, 6'b010010, 0);
    fill_one(19'h0020, 8'h02, 20'h00BBB, 6'b010010, 0);
    @(negedge clk); jt_wr = 1; jt_wr_keep = 1;
    @(negedge clk); jt_wr = 0; jt_wr_keep = 0;
    probe(19'h0010, 8'h02, h, p, pm);
    check(h == 1 && p == 20'h00AAA, "R6 keep-write leaves entry", p, 20'h00AAA);
    probe(19'h0020, 8'h02, h, p, pm);
    check(h == 1 && p == 20'h00BBB, "R6 keep-write leaves second entry", p, 20'h00BBB);
    @(negedge clk); jt_wr = 1;
    @(negedge clk); jt_wr = 0;
    probe(19'h0010, 8'h02, h, p, pm);
    check(h == 0, "R7 normal write flushes", h, 0);
    probe(19'h0020, 8'h02, h, p, pm);
    check(h == 0, "R7 normal write flushes all", h, 0);
    fill_one(19'h0030, 8'h02, 20'h00CCC, 6'b000001, 1);
    probe(19'h0030, 8'h02, h, p, pm);
    check(h == 1, "R8 entry present before invalidate", h, 1);
    @(negedge clk); inv_cmd = 1;
    @(negedge clk); inv_cmd = 0;
    probe(19'h0030, 8'h02, h, p, pm);
    check(h == 0, "R8 invalidate command flushes", h, 0);
  endtask

  task automatic t_flush_vs_fill();
    logic h; logic [PW-1:0] p; logic [5:0] pm;
    reset_dut();
    @(negedge clk);
    lk_valid = 1; lk_vpn = 19'h0444; lk_asid = 8'h07;
    @(negedge clk);
    lk_valid = 0; fill_ack = 1; fill_pfn = 20'h44444; inv_cmd = 1;
    @(negedge clk);
    fill_ack = 0; inv_cmd = 0;
    check(fill_req == 0, "R9 request ends despite flush", fill_req, 0);
    probe(19'h0444, 8'h07, h, p, pm);
    check(h == 0, "R9 flush wins over fill", h, 0);
  endtask

  task automatic t_stray_ack();
    logic h; logic [PW-1:0] p; logic [5:0] pm;
    reset_dut();
    @(negedge clk);
    fill_ack = 1; fill_pfn = 20'h00077; fill_global = 1;
    @(negedge clk);
    fill_ack = 0; fill_global = 0;
    check(fill_req == 0, "R10 stray ack leaves request low", fill_req, 0);
    probe(19'h0, 8'h0, h, p, pm);
    check(h == 0, "R10 stray ack installs nothing", h, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_hit_rules();
    t_miss_request();
    t_round_robin();
    t_writes();
    t_flush_vs_fill();
    t_stray_ack();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule